// File: doc/BRIEF.md
# GPIO Controller with Edge-Cause Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins; the pin count is a parameter. Software reaches it through a simple 32-bit register port. The port picks one of four windows with a 2-bit window code and a byte offset. Output data and output-enable bits change only through a write-one-to-set window and a write-one-to-clear window. Each pin can therefore be driven or released without a read-modify-write, and without a lock shared with other software agents.

Each pin input passes through a synchroniser. Software can read the synchronised level and can enable rising-edge detection, falling-edge detection or both for each pin. A detected edge latches into a per-pin cause bit. A separate event-enable mask decides which causes reach the single level-sensitive interrupt output and the masked cause read-back. Software acknowledges causes by writing ones to a clear offset. An edge that arrives in the same cycle as its own clear is kept.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register is zero: output enables, output data, both edge enables, event enables and causes. The pin_oe, pin_out and irq outputs are low.
- R2: A write to window 2 (set) at offset 0x00 sets each output-enable bit whose write bit is 1. At offset 0x04 it sets output-data bits the same way. Bits written as 0 keep their value. Reads of windows 2 and 3 return output enables at 0x00 and output data at 0x04.
- R3: A write to window 3 (clear) at offset 0x00 clears each output-enable bit whose write bit is 1. At offset 0x04 it clears output-data bits the same way. Bits written as 0 keep their value.
- R4: In window 0 (config), offset 0x00 is a plain read/write rising-edge enable and offset 0x04 is a plain read/write falling-edge enable.
- R5: Window 0, offset 0x08 reads the synchronised pin levels. A pin change is not visible after one rising clock edge. It is visible after the second rising clock edge (two-flop synchroniser).
- R6: A pin with only the rising enable latches a cause on a 0-to-1 change only. A pin with only the falling enable latches a cause on a 1-to-0 change only. A pin with both enables latches a cause on either change. The cause bit is set by the third rising clock edge after the pin changes.
- R7: Window 1 (cause), offset 0x14 is a read/write event-enable mask. Window 1, offset 0x00 reads the latched causes ANDed with that mask. Causes latch even while masked.
- R8: A write to window 1, offset 0x18 clears each cause bit written as 1 and leaves bits written as 0 alone. This lets software clear a stale cause before unmasking it.
- R9: irq is the OR of all masked cause bits. It stays high until every masked cause is cleared or masked.
- R10: If an enabled edge on a pin and a clear of that pin's cause bit land on the same clock edge, the cause stays set.
- R11: Register bits at or above the pin count read as zero, and writes to them have no effect. Offsets not named above read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_win | input | 2 | Window select: 0 config, 1 cause, 2 set, 3 clear |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data register |
| pin_oe | output | NPINS | Output-enable register |
| irq | output | 1 | Level interrupt, OR of masked causes |

## Verification
The assertions assume that every write presents its window, offset and data for exactly the cycle in which bus_wr is high. They also assume that pin inputs may change at any time relative to software activity, but never more than once between clock edges. The stimulus changes all inputs only shortly after a falling clock edge. Directed pin changes are held for at least three clock cycles, so each edge passes cleanly through the synchroniser. The collision case is set up by timing a clear write onto the exact cycle in which the edge is detected. The random phase changes pins at most once per cycle, in keeping with a synchronised input.

// File: rtl/gpec_pkg.sv
package gpec_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 5;

   typedef enum logic [1:0] {
      WIN_CFG   = 2'd0,
      WIN_CAUSE = 2'd1,
      WIN_SET   = 2'd2,
      WIN_CLR   = 2'd3
   } gpec_win_e;

   localparam logic [ADDR_W-1:0] OFF_LO    = 5'h00;
   localparam logic [ADDR_W-1:0] OFF_HI    = 5'h04;
   localparam logic [ADDR_W-1:0] OFF_LEVEL = 5'h08;
   localparam logic [ADDR_W-1:0] OFF_EVT   = 5'h14;
   localparam logic [ADDR_W-1:0] OFF_ACK   = 5'h18;
endpackage

// File: rtl/gpec_sync_edge.sv
module gpec_sync_edge #(
   parameter int NPINS      = 32,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] rise_en,
   input  logic [NPINS-1:0] fall_en,
   output logic [NPINS-1:0] level,
   output logic [NPINS-1:0] edge_hit
);
   if (SYNC_DEPTH < 2) begin : g_bad_depth
      $error("gpec_sync_edge: SYNC_DEPTH must be at least 2");
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [SYNC_DEPTH-1:0] chain;
      logic                  last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
         end else begin
            chain <= {chain[SYNC_DEPTH-2:0], pin_in[p]};
            last  <= chain[SYNC_DEPTH-1];
         end
      end

      assign level[p]    = chain[SYNC_DEPTH-1];
      assign edge_hit[p] = (rise_en[p] &  chain[SYNC_DEPTH-1] & ~last) |
                           (fall_en[p] & ~chain[SYNC_DEPTH-1] &  last);
   end
endmodule

// File: rtl/gpec_regs.sv
module gpec_regs
   import gpec_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_win,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NPINS-1:0]  level,
   input  logic [NPINS-1:0]  cause_masked,
   output logic [NPINS-1:0]  oe_q,
   output logic [NPINS-1:0]  dout_q,
   output logic [NPINS-1:0]  rise_q,
   output logic [NPINS-1:0]  fall_q,
   output logic [NPINS-1:0]  evt_q,
   output logic [NPINS-1:0]  clr_vec,
   output logic [DATA_W-1:0] bus_rdata
);
   logic [NPINS-1:0] wbits;
   logic             wr_cfg, wr_cause, wr_set, wr_clr;
   logic [NPINS-1:0] rd_v;

   assign wbits    = bus_wdata[NPINS-1:0];
   assign wr_cfg   = bus_wr && (bus_win == WIN_CFG);
   assign wr_cause = bus_wr && (bus_win == WIN_CAUSE);
   assign wr_set   = bus_wr && (bus_win == WIN_SET);
   assign wr_clr   = bus_wr && (bus_win == WIN_CLR);

   assign clr_vec = (wr_cause && bus_addr == OFF_ACK) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= '0;
         dout_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
         evt_q  <= '0;
      end else begin
         if (wr_set && bus_addr == OFF_LO) oe_q   <= oe_q | wbits;
         if (wr_clr && bus_addr == OFF_LO) oe_q   <= oe_q & ~wbits;
         if (wr_set && bus_addr == OFF_HI) dout_q <= dout_q | wbits;
         if (wr_clr && bus_addr == OFF_HI) dout_q <= dout_q & ~wbits;
         if (wr_cfg && bus_addr == OFF_LO) rise_q <= wbits;
         if (wr_cfg && bus_addr == OFF_HI) fall_q <= wbits;
         if (wr_cause && bus_addr == OFF_EVT) evt_q <= wbits;
      end
   end

   always_comb begin
      rd_v = '0;
      unique case (bus_win)
         WIN_CFG: begin
            if (bus_addr == OFF_LO)    rd_v = rise_q;
            if (bus_addr == OFF_HI)    rd_v = fall_q;
            if (bus_addr == OFF_LEVEL) rd_v = level;
         end
         WIN_CAUSE: begin
            if (bus_addr == OFF_LO)  rd_v = cause_masked;
            if (bus_addr == OFF_EVT) rd_v = evt_q;
         end
         default: begin
            if (bus_addr == OFF_LO) rd_v = oe_q;
            if (bus_addr == OFF_HI) rd_v = dout_q;
         end
      endcase
      bus_rdata             = '0;
      bus_rdata[NPINS-1:0]  = rd_v;
   end
endmodule

// File: rtl/gpec_cause.sv
module gpec_cause #(
   parameter int NPINS          = 32,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] edge_hit,
   input  logic [NPINS-1:0] clr_vec,
   input  logic [NPINS-1:0] evt_en,
   output logic [NPINS-1:0] cause_raw,
   output logic [NPINS-1:0] cause_masked,
   output logic             irq
);
   logic any_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_raw <= '0;
      else        cause_raw <= (cause_raw & ~clr_vec) | edge_hit;
   end

   assign cause_masked = cause_raw & evt_en;
   assign any_pending  = |cause_masked;

   if (IRQ_REGISTERED) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_pending;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = any_pending;
   end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpec_pkg::*;
#(
   parameter int NPINS          = 32,
   parameter int SYNC_DEPTH     = 2,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_win,
   input  logic [4:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpio_edge_ctrl: NPINS must be within 1..32");
   end

   logic [NPINS-1:0] level;
   logic [NPINS-1:0] edge_hit;
   logic [NPINS-1:0] rise_en;
   logic [NPINS-1:0] fall_en;
   logic [NPINS-1:0] evt_en;
   logic [NPINS-1:0] clr_vec;
   logic [NPINS-1:0] cause_raw;
   logic [NPINS-1:0] cause_masked;

   gpec_sync_edge #(.NPINS(NPINS), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .rise_en  (rise_en),
      .fall_en  (fall_en),
      .level    (level),
      .edge_hit (edge_hit)
   );

   gpec_regs #(.NPINS(NPINS)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_win      (bus_win),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .level        (level),
      .cause_masked (cause_masked),
      .oe_q         (pin_oe),
      .dout_q       (pin_out),
      .rise_q       (rise_en),
      .fall_q       (fall_en),
      .evt_q        (evt_en),
      .clr_vec      (clr_vec),
      .bus_rdata    (bus_rdata)
   );

   gpec_cause #(.NPINS(NPINS), .IRQ_REGISTERED(IRQ_REGISTERED)) u_cause (
      .clk          (clk),
      .rst_n        (rst_n),
      .edge_hit     (edge_hit),
      .clr_vec      (clr_vec),
      .evt_en       (evt_en),
      .cause_raw    (cause_raw),
      .cause_masked (cause_masked),
      .irq          (irq)
   );
endmodule

// File: rtl/gpec_chk.sv
module gpec_chk #(
   parameter int NPINS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_win,
   input logic [4:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] pin_out,
   input logic             irq,
   input logic [NPINS-1:0] evt_en,
   input logic [NPINS-1:0] edge_hit,
   input logic [NPINS-1:0] clr_vec,
   input logic [NPINS-1:0] cause_raw
);
   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

   // R2
   set_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_win == 2'd2 && bus_addr == 5'h00) |=>
      ((pin_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

   // R3
   clr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_win == 2'd3 && bus_addr == 5'h04) |=>
      ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0) |=> ((cause_raw & $past(clr_vec & ~edge_hit)) == '0));

   // R9
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_en == '0 && $past(evt_en) == '0) |-> !irq);

   // R10
   edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit != '0) |=> ((cause_raw & $past(edge_hit)) == $past(edge_hit)));
endmodule

bind gpio_edge_ctrl gpec_chk #(.NPINS(NPINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_win   (bus_win),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out),
   .irq       (irq),
   .evt_en    (evt_en),
   .edge_hit  (edge_hit),
   .clr_vec   (clr_vec),
   .cause_raw (cause_raw)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
   localparam int          NP   = 24;
   localparam logic [31:0] MASK = 32'h00FF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_win = 2'd0;
   logic [4:0]    bus_addr = 5'h00;
   logic [31:0]   bus_wdata = 32'h0;
   logic [NP-1:0] pin_in = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   gpio_edge_ctrl #(.NPINS(NP)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_win   (bus_win),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   // behavioural reference state
   logic [31:0] m_oe, m_do, m_re, m_fe, m_ev, m_ca;
   logic [31:0] m_hist [$];
   logic [31:0] m_lvl, m_prev, m_hit, m_wb, m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_oe = 0; m_do = 0; m_re = 0; m_fe = 0; m_ev = 0; m_ca = 0;
         m_hist = '{0, 0, 0};
      end else begin
         m_lvl  = m_hist[1];
         m_prev = m_hist[2];
         m_hit  = (m_re & m_lvl & ~m_prev) | (m_fe & ~m_lvl & m_prev);
         m_wb   = bus_wdata & MASK;
         m_clr  = (bus_wr && bus_win == 2'd1 && bus_addr == 5'h18) ? m_wb : 32'h0;
         m_ca   = (m_ca & ~m_clr) | m_hit;
         m_hist.push_front({8'h0, pin_in});
         void'(m_hist.pop_back());
         if (bus_wr) begin
            case (bus_win)
               2'd0: begin
                  if (bus_addr == 5'h00) m_re = m_wb;
                  if (bus_addr == 5'h04) m_fe = m_wb;
               end
               2'd1: if (bus_addr == 5'h14) m_ev = m_wb;
               2'd2: begin
                  if (bus_addr == 5'h00) m_oe = m_oe | m_wb;
                  if (bus_addr == 5'h04) m_do = m_do | m_wb;
               end
               default: begin
                  if (bus_addr == 5'h00) m_oe = m_oe & ~m_wb;
                  if (bus_addr == 5'h04) m_do = m_do & ~m_wb;
               end
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read();
      case (bus_win)
         2'd0: return (bus_addr == 5'h00) ? m_re : (bus_addr == 5'h04) ? m_fe :
                      (bus_addr == 5'h08) ? m_hist[1] : 32'h0;
         2'd1: return (bus_addr == 5'h00) ? (m_ca & m_ev) :
                      (bus_addr == 5'h14) ? m_ev : 32'h0;
         default: return (bus_addr == 5'h00) ? m_oe :
                         (bus_addr == 5'h04) ? m_do : 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done && m_hist.size() == 3) begin
         chk("R2 R3 pin_oe", {8'h0, pin_oe}, m_oe);
         chk("R2 R3 pin_out", {8'h0, pin_out}, m_do);
         chk("R9 irq", {31'h0, irq}, {31'h0, |(m_ca & m_ev)});
         chk("R4 R5 R7 R11 rdata", bus_rdata, m_read());
      end
   end

   task automatic wr(input logic [1:0] w, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_win = w; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] w, input logic [4:0] a,
                     input logic [31:0] exp, input string tag);
      bus_wr = 1'b0; bus_win = w; bus_addr = a;
      #0.5;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic pins(input logic [31:0] v);
      @(negedge clk); #1;
      pin_in = v[NP-1:0];
      repeat (3) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R1 reset state
      rd(2'd0, 5'h00, 32'h0, "R1 rise_en");
      rd(2'd0, 5'h04, 32'h0, "R1 fall_en");
      rd(2'd0, 5'h08, 32'h0, "R1 level");
      rd(2'd1, 5'h00, 32'h0, "R1 cause");
      rd(2'd1, 5'h14, 32'h0, "R1 evt_en");
      rd(2'd2, 5'h00, 32'h0, "R1 oe");
      rd(2'd3, 5'h04, 32'h0, "R1 dout");
      chk("R1 pin_oe", {8'h0, pin_oe}, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R2 set window, R11 upper bits
      wr(2'd2, 5'h00, 32'hFFFF_00F0);
      rd(2'd2, 5'h00, 32'h00FF_00F0, "R2 R11 oe set");
      wr(2'd2, 5'h00, 32'h0000_000F);
      rd(2'd2, 5'h00, 32'h00FF_00FF, "R2 oe zeros kept");
      wr(2'd2, 5'h04, 32'h0000_00A5);
      chk("R2 pin_out", {8'h0, pin_out}, 32'h0000_00A5);

      // R3 clear window
      wr(2'd3, 5'h00, 32'h00FF_0000);
      rd(2'd3, 5'h00, 32'h0000_00FF, "R3 oe clear");
      wr(2'd3, 5'h04, 32'h0000_0005);
      chk("R3 pin_out", {8'h0, pin_out}, 32'h0000_00A0);
      chk("R3 pin_oe", {8'h0, pin_oe}, 32'h0000_00FF);

      // R4 edge enables, R11
      wr(2'd0, 5'h00, 32'hFFFF_FFFF);
      rd(2'd0, 5'h00, 32'h00FF_FFFF, "R4 R11 rise_en");
      wr(2'd0, 5'h04, 32'h1234_5678);
      rd(2'd0, 5'h04, 32'h0034_5678, "R4 fall_en");
      rd(2'd0, 5'h0C, 32'h0, "R11 unmapped");
      rd(2'd1, 5'h08, 32'h0, "R11 unmapped cause");
      wr(2'd0, 5'h00, 32'h0000_000D);
      wr(2'd0, 5'h04, 32'h0000_0006);

      // R5 synchroniser latency
      @(negedge clk); #1;
      pin_in = 24'h80_0000;
      @(negedge clk); #1;
      rd(2'd0, 5'h08, 32'h0, "R5 not yet visible");
      @(negedge clk); #1;
      rd(2'd0, 5'h08, 32'h0080_0000, "R5 visible");

      // R7 event enable
      wr(2'd1, 5'h14, 32'hFFFF_FFF7);
      rd(2'd1, 5'h14, 32'h00FF_FFF7, "R7 evt_en");

      // R6 rising only (bit 0)
      pins(32'h0080_0001);
      rd(2'd1, 5'h00, 32'h1, "R6 rise latched");
      chk("R9 irq high", {31'h0, irq}, 32'h1);
      wr(2'd1, 5'h18, 32'h1);
      rd(2'd1, 5'h00, 32'h0, "R8 cleared");
      chk("R9 irq low", {31'h0, irq}, 32'h0);
      pins(32'h0080_0000);
      rd(2'd1, 5'h00, 32'h0, "R6 fall ignored on rise-only");

      // R6 falling only (bit 1)
      pins(32'h0080_0002);
      rd(2'd1, 5'h00, 32'h0, "R6 rise ignored on fall-only");
      pins(32'h0080_0000);
      rd(2'd1, 5'h00, 32'h2, "R6 fall latched");

      // R6 both edges (bit 2), R9 partial clear
      pins(32'h0080_0004);
      rd(2'd1, 5'h00, 32'h6, "R6 both rise");
      wr(2'd1, 5'h18, 32'h2);
      rd(2'd1, 5'h00, 32'h4, "R8 other bit kept");
      chk("R9 irq stays", {31'h0, irq}, 32'h1);
      wr(2'd1, 5'h18, 32'h4);
      chk("R9 irq drops", {31'h0, irq}, 32'h0);
      pins(32'h0080_0000);
      rd(2'd1, 5'h00, 32'h4, "R6 both fall");
      wr(2'd1, 5'h18, 32'h4);

      // R7 masked latch, then unmask
      pins(32'h0080_0008);
      rd(2'd1, 5'h00, 32'h0, "R7 masked read");
      chk("R7 irq masked", {31'h0, irq}, 32'h0);
      wr(2'd1, 5'h14, 32'h00FF_FFFF);
      rd(2'd1, 5'h00, 32'h8, "R7 latched while masked");
      wr(2'd1, 5'h18, 32'h8);
      rd(2'd1, 5'h00, 32'h0, "R8 clear");
      // R8 stale cause cleared before unmask
      wr(2'd1, 5'h14, 32'h00FF_FFF7);
      pins(32'h0080_0000);
      pins(32'h0080_0008);
      wr(2'd1, 5'h18, 32'h8);
      wr(2'd1, 5'h14, 32'h00FF_FFFF);
      rd(2'd1, 5'h00, 32'h0, "R8 stale cleared before unmask");
      chk("R8 irq quiet", {31'h0, irq}, 32'h0);

      // R8 zeros kept, two causes
      pins(32'h0080_0005);
      rd(2'd1, 5'h00, 32'h5, "R6 two rises");
      wr(2'd1, 5'h18, 32'h1);
      rd(2'd1, 5'h00, 32'h4, "R8 zero bits untouched");
      wr(2'd1, 5'h18, 32'h4);

      // R10 edge and clear on the same clock edge
      pins(32'h0080_0004);
      rd(2'd1, 5'h00, 32'h0, "R10 precondition");
      @(negedge clk); #1;
      pin_in = 24'h80_0005;
      @(negedge clk);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_win = 2'd1; bus_addr = 5'h18; bus_wdata = 32'h1;
      @(negedge clk); #1;
      bus_wr = 1'b0;
      rd(2'd1, 5'h00, 32'h1, "R10 edge wins");
      wr(2'd1, 5'h18, 32'h1);

      // mixed traffic compared every cycle
      for (int i = 0; i < 800; i++) begin
         @(negedge clk); #1;
         if (($urandom % 4) == 0) pin_in = pin_in ^ NP'($urandom);
         bus_wr    = (($urandom % 3) == 0);
         bus_win   = 2'($urandom);
         case ($urandom % 5)
            0: bus_addr = 5'h00;
            1: bus_addr = 5'h04;
            2: bus_addr = 5'h08;
            3: bus_addr = 5'h14;
            default: bus_addr = 5'h18;
         endcase
         bus_wdata = $urandom;
      end
      @(negedge clk); #1;
      bus_wr = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule